// File: doc/BRIEF.md
# Jitter Attenuator Elastic Bit FIFO

This block smooths the timing of a recovered bit stream for one line channel. Bits come in with a single-cycle write strobe whose spacing wanders. They are held in an elastic bit buffer, and they leave on a read strobe that a digital phase accumulator produces. The frequency word of the accumulator is a nominal rate for the line mode, T1 or E1, plus a correction taken from how far the buffer fill is from its midpoint. A right-shift of that correction sets the loop bandwidth, and so how much jitter is filtered out.

A narrow loop filters well but drifts slowly. When the fill comes within two bits of empty or full, the block changes on its own to a wide tracking gain, so that the output follows the input and no bits are dropped. It returns to the narrow setting once the fill is back inside the safe band. In T1 mode one narrow setting is always used. In E1 mode a select picks a medium or a very narrow setting, and the very narrow setting also forces the deep buffer. After reset, reading waits until half the active depth has been written, which gives a nominal delay of half the depth. An overflow or underflow that still happens recentres the buffer and sets a sticky error flag.

Top module: `jitterSmoother`

## Requirements
- R1: After reset, outStrobe and errSticky are 0 and wideTrack is 1, because the empty buffer lies inside the guard band.
- R2: In T1 mode the active depth is 32 bits when deepSel is 0 and 64 bits when deepSel is 1.
- R3: After reset no bit is read until half the active depth has been written. The first read comes after between half and half plus two writes, and bits leave in the order they were written, each read shown by a one-cycle outStrobe with the bit on outBit.
- R4: wideTrack is 1 while the fill is at most 2 or at least the active depth minus 2, and 0 otherwise. It is 0 in steady state near half fill and 1 while the buffer drains towards empty.
- R5: In T1 mode with depth 32, writes arriving every 7 cycles against a nominal read spacing of 8 cycles are absorbed by the wide tracking gain, with no overflow and no lost or reordered bit.
- R6: In T1 mode bwSel has no effect: the same write pattern gives the same outStrobe timing with bwSel at 0 or 1.
- R7: In E1 mode with bwSel at 1 (narrowest setting) the active depth is 64 bits even when deepSel is 0.
- R8: In E1 mode with bwSel at 0 the active depth follows deepSel (32 bits when deepSel is 0).
- R9: A write into a full buffer, or a read tick on an empty buffer, sets errSticky. The buffer recentres to half fill, errSticky stays 1 until errClear is pulsed, and then it reads 0 on the next cycle. Afterwards normal traffic runs without a new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the line rate |
| rstN | input | 1 | Active-low synchronous reset |
| inBit | input | 1 | Incoming data bit |
| inStrobe | input | 1 | One-cycle write enable for inBit |
| modeE1 | input | 1 | 1 = E1 line mode, 0 = T1 line mode |
| deepSel | input | 1 | 1 requests the 64-bit depth, 0 the 32-bit depth |
| bwSel | input | 1 | E1 only: 1 = narrowest bandwidth, 0 = medium |
| errClear | input | 1 | Clears the sticky fault flag |
| outBit | output | 1 | Smoothed output bit |
| outStrobe | output | 1 | One-cycle strobe marking a valid outBit |
| wideTrack | output | 1 | Loop is in the wide tracking gain |
| errSticky | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench counts the writes before the first read under each depth and mode combination. A design that ignored the forced deep buffer, or opened reading at the wrong fill, would show the first read after 16 writes where 32 are expected, or the reverse. A fast writer at 7-cycle spacing tests the guard band: without the wide gain, the narrow loop lets the fill reach full and raises the fault flag. A replayed pattern with bwSel flipped in T1 mode catches a design that lets the select change the loop gain. Starving the buffer and flooding it check that the fault flag sets, holds and clears, and that traffic resumes cleanly after recentring.

// File: rtl/smootherPkg.sv
package smootherPkg;

  // strobes from the control to the datapath, one cycle wide
  typedef struct packed {
    logic doWrite;
    logic doRead;
    logic recentre;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    BAND_WIDE    = 2'd0,
    BAND_T1      = 2'd1,
    BAND_E1_MED  = 2'd2,
    BAND_E1_SLOW = 2'd3
  } band_e;

endpackage

// File: rtl/smootherDatapath.sv
module smootherDatapath
  import smootherPkg::*;
#(
  parameter int MAX_DEPTH = 64,
  localparam int PTR_W = $clog2(MAX_DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inBit,
  input  ctlStrobes_t      st,
  input  logic [CNT_W-1:0] depthBits,
  output logic [CNT_W-1:0] fill,
  output logic             outBit,
  output logic             outStrobe
);

  logic             mem [MAX_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W-1:0] addrMask, wrAddr, rdAddr;
  logic [CNT_W-1:0] halfBits;

  assign addrMask = PTR_W'(depthBits - CNT_W'(1));
  assign wrAddr   = wrPtr & addrMask;
  assign rdAddr   = rdPtr & addrMask;
  assign halfBits = depthBits >> 1;

  always_ff @(posedge clk) begin
    if (st.doWrite) mem[wrAddr] <= inBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fill      <= '0;
      outBit    <= 1'b0;
      outStrobe <= 1'b0;
    end else if (st.recentre) begin
      rdPtr     <= wrPtr - PTR_W'(halfBits);
      fill      <= halfBits;
      outStrobe <= 1'b0;
    end else begin
      if (st.doWrite) wrPtr <= wrPtr + PTR_W'(1);
      if (st.doRead) begin
        rdPtr  <= rdPtr + PTR_W'(1);
        outBit <= mem[rdAddr];
      end
      outStrobe <= st.doRead;
      fill <= fill + CNT_W'(st.doWrite) - CNT_W'(st.doRead);
    end
  end

  // the fill never passes the active depth outside a recentre cycle
  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    !st.recentre |-> fill <= depthBits);

  // control never issues a read on an empty buffer
  p_read_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.doRead |-> fill != '0);

  // a write without a read needs room
  p_write_room_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.doWrite && !st.doRead) |-> fill < depthBits);

endmodule

// File: rtl/smootherControl.sv
module smootherControl
  import smootherPkg::*;
#(
  parameter int MAX_DEPTH = 64,
  parameter int WIN       = 2,
  parameter int ACC_W     = 16,
  parameter int NOM_T1    = 8192,
  parameter int NOM_E1    = 10923,
  parameter int GAIN_SH   = 8,
  parameter int SH_WIDE   = 0,
  parameter int SH_T1     = 6,
  parameter int SH_E1_MED = 4,
  parameter int SH_E1_SLOW = 8,
  localparam int PTR_W = $clog2(MAX_DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int SUM_W = ACC_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inStrobe,
  input  logic             modeE1,
  input  logic             deepSel,
  input  logic             bwSel,
  input  logic             errClear,
  input  logic [CNT_W-1:0] fill,
  output ctlStrobes_t      st,
  output logic [CNT_W-1:0] depthBits,
  output logic             wideTrack,
  output logic             errSticky
);

  logic                    effDeep, effDeepQ, depthChg;
  logic [CNT_W-1:0]        halfBits;
  band_e                   band;
  int unsigned             shiftAmt;
  logic signed [CNT_W:0]   fillErr;
  logic signed [SUM_W-1:0] scaled, corr, nomWord, freqSum;
  logic [ACC_W-1:0]        acc, accNext, freqWord;
  logic                    tick, priming, readReq, overflow, underflow, fault;

  // depth: the narrowest E1 setting forces the deep buffer
  assign effDeep   = deepSel | (modeE1 & bwSel);
  assign depthBits = effDeep ? CNT_W'(MAX_DEPTH) : CNT_W'(MAX_DEPTH / 2);
  assign halfBits  = depthBits >> 1;
  assign depthChg  = effDeep != effDeepQ;

  // guard band near either end of the buffer
  assign wideTrack = (fill <= CNT_W'(WIN)) || (fill >= depthBits - CNT_W'(WIN));

  always_comb begin
    if (wideTrack)    band = BAND_WIDE;
    else if (!modeE1) band = BAND_T1;
    else if (bwSel)   band = BAND_E1_SLOW;
    else              band = BAND_E1_MED;
  end

  always_comb begin
    case (band)
      BAND_WIDE:    shiftAmt = SH_WIDE;
      BAND_T1:      shiftAmt = SH_T1;
      BAND_E1_MED:  shiftAmt = SH_E1_MED;
      default:      shiftAmt = SH_E1_SLOW;
    endcase
  end

  // frequency word: nominal rate plus scaled fill error
  assign fillErr = $signed({1'b0, fill}) - $signed({1'b0, halfBits});
  assign scaled  = {{(SUM_W - CNT_W - 1){fillErr[CNT_W]}}, fillErr} <<< GAIN_SH;
  assign corr    = scaled >>> shiftAmt;
  assign nomWord = modeE1 ? SUM_W'(NOM_E1) : SUM_W'(NOM_T1);
  assign freqSum = nomWord + corr;

  always_comb begin
    if (freqSum[SUM_W-1])      freqWord = '0;
    else if (freqSum[ACC_W])   freqWord = '1;
    else                       freqWord = freqSum[ACC_W-1:0];
  end

  assign {tick, accNext} = {1'b0, acc} + {1'b0, freqWord};

  assign readReq   = tick & ~priming;
  assign overflow  = inStrobe & ~readReq & (fill == depthBits);
  assign underflow = readReq & (fill == '0);
  assign fault     = overflow | underflow;

  assign st.recentre = fault | depthChg;
  assign st.doWrite  = inStrobe & ~st.recentre;
  assign st.doRead   = readReq & ~st.recentre;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      priming   <= 1'b1;
      effDeepQ  <= effDeep;
      errSticky <= 1'b0;
    end else begin
      acc      <= accNext;
      effDeepQ <= effDeep;
      if (st.recentre)                   priming <= 1'b0;
      else if (priming && fill >= halfBits) priming <= 1'b0;
      if (fault)         errSticky <= 1'b1;
      else if (errClear) errSticky <= 1'b0;
    end
  end

  // flag stays set until cleared
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !errClear) |=> errSticky);

  // a clear with no new fault drops the flag
  p_sticky_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && !fault) |=> !errSticky);

  // a fault can only happen with the loop already in wide tracking
  p_wide_at_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> wideTrack);

endmodule

// File: rtl/jitterSmoother.sv
module jitterSmoother
  import smootherPkg::*;
#(
  parameter int MAX_DEPTH  = 64,
  parameter int WIN        = 2,
  parameter int ACC_W      = 16,
  parameter int NOM_T1     = 8192,
  parameter int NOM_E1     = 10923,
  parameter int GAIN_SH    = 8,
  parameter int SH_WIDE    = 0,
  parameter int SH_T1      = 6,
  parameter int SH_E1_MED  = 4,
  parameter int SH_E1_SLOW = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic inBit,
  input  logic inStrobe,
  input  logic modeE1,
  input  logic deepSel,
  input  logic bwSel,
  input  logic errClear,
  output logic outBit,
  output logic outStrobe,
  output logic wideTrack,
  output logic errSticky
);

  localparam int CNT_W = $clog2(MAX_DEPTH) + 1;

  ctlStrobes_t      st;
  logic [CNT_W-1:0] fill, depthBits;

  smootherControl #(
    .MAX_DEPTH(MAX_DEPTH), .WIN(WIN), .ACC_W(ACC_W),
    .NOM_T1(NOM_T1), .NOM_E1(NOM_E1), .GAIN_SH(GAIN_SH),
    .SH_WIDE(SH_WIDE), .SH_T1(SH_T1), .SH_E1_MED(SH_E1_MED), .SH_E1_SLOW(SH_E1_SLOW)
  ) uCtl (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .modeE1(modeE1),
    .deepSel(deepSel), .bwSel(bwSel), .errClear(errClear), .fill(fill),
    .st(st), .depthBits(depthBits), .wideTrack(wideTrack), .errSticky(errSticky)
  );

  smootherDatapath #(.MAX_DEPTH(MAX_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .inBit(inBit), .st(st), .depthBits(depthBits),
    .fill(fill), .outBit(outBit), .outStrobe(outStrobe)
  );

endmodule

// File: tb/sim_jitterSmoother.sv
module sim_jitterSmoother;

  logic clk = 1'b0;
  logic rstN, inBit, inStrobe, modeE1, deepSel, bwSel, errClear;
  logic outBit, outStrobe, wideTrack, errSticky;

  always #2.5 clk = ~clk;

  jitterSmoother u0 (
    .clk(clk), .rstN(rstN), .inBit(inBit), .inStrobe(inStrobe),
    .modeE1(modeE1), .deepSel(deepSel), .bwSel(bwSel), .errClear(errClear),
    .outBit(outBit), .outStrobe(outStrobe), .wideTrack(wideTrack), .errSticky(errSticky)
  );

  int total = 0;
  int bad = 0;
  bit expQ[$];
  bit trackData;
  int wrCount, firstAt, cycIdx, gapRem;
  bit firstSeen, sawWide;
  longint unsigned sig;
  int gapTab[256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit inRange(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic step(input bit wr);
    @(negedge clk);
    cycIdx++;
    if (wideTrack) sawWide = 1'b1;
    if (outStrobe) begin
      sig = sig * 64'd31 + longint'(cycIdx);
      if (!firstSeen) begin
        firstSeen = 1'b1;
        firstAt = wrCount;
      end
      if (trackData) begin
        if (expQ.size() == 0) check(1'b0, "R3 read with nothing written", 1, 0);
        else begin
          bit e;
          e = expQ.pop_front();
          check(outBit == e, "R3 bit order", int'(outBit), int'(e));
        end
      end
    end
    errClear = 1'b0;
    inStrobe = wr;
    inBit = 1'($urandom % 2);
    if (wr) begin
      wrCount++;
      if (trackData) expQ.push_back(inBit);
    end
  endtask

  task automatic doReset(input bit e1, input bit deep, input bit bw);
    @(negedge clk);
    rstN = 1'b0; inStrobe = 1'b0; inBit = 1'b0; errClear = 1'b0;
    modeE1 = e1; deepSel = deep; bwSel = bw;
    expQ.delete();
    wrCount = 0; firstSeen = 1'b0; firstAt = -1; cycIdx = 0; sig = 0;
    sawWide = 1'b0; trackData = 1'b1; gapRem = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  // jittered writes: spacing base +/-2; useTab replays a fixed gap list
  task automatic runJitter(input int base, input int cycles, input bit useTab, input bit jit);
    int k;
    k = 0;
    for (int c = 0; c < cycles; c++) begin
      if (gapRem == 0) begin
        if (useTab) gapRem = base + gapTab[k % 256];
        else if (jit) gapRem = base + int'($urandom % 5) - 2;
        else gapRem = base;
        k++;
        gapRem = gapRem - 1;
        step(1'b1);
      end else begin
        gapRem = gapRem - 1;
        step(1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint unsigned sigA;
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) gapTab[i] = int'($urandom % 5) - 2;
    rstN = 1'b0; inStrobe = 1'b0; inBit = 1'b0; errClear = 1'b0;
    modeE1 = 1'b0; deepSel = 1'b0; bwSel = 1'b0;

    // R1 reset state
    doReset(1'b0, 1'b0, 1'b0);
    step(1'b0);
    check(outStrobe == 1'b0, "R1 outStrobe after reset", int'(outStrobe), 0);
    check(errSticky == 1'b0, "R1 errSticky after reset", int'(errSticky), 0);
    check(wideTrack == 1'b1, "R1 wideTrack when empty", int'(wideTrack), 1);

    // R2 T1 shallow: first read after 16 writes
    runJitter(8, 3000, 1'b0, 1'b1);
    check(inRange(firstAt, 16, 18), "R2 R3 T1 depth32 first read", firstAt, 16);
    check(errSticky == 1'b0, "R3 no fault in steady T1", int'(errSticky), 0);
    check(wideTrack == 1'b0, "R4 narrow in steady state", int'(wideTrack), 0);

    // R2 T1 deep: first read after 32 writes
    doReset(1'b0, 1'b1, 1'b0);
    runJitter(8, 3000, 1'b0, 1'b1);
    check(inRange(firstAt, 32, 34), "R2 T1 depth64 first read", firstAt, 32);
    check(errSticky == 1'b0, "R2 no fault T1 depth64", int'(errSticky), 0);

    // R7 E1 narrowest forces deep buffer
    doReset(1'b1, 1'b0, 1'b1);
    runJitter(6, 3000, 1'b0, 1'b1);
    check(inRange(firstAt, 32, 34), "R7 E1 slow forces depth64", firstAt, 32);
    check(errSticky == 1'b0, "R7 no fault E1 slow", int'(errSticky), 0);

    // R8 E1 medium follows deepSel
    doReset(1'b1, 1'b0, 1'b0);
    runJitter(6, 3000, 1'b0, 1'b1);
    check(inRange(firstAt, 16, 18), "R8 E1 medium depth32", firstAt, 16);
    check(errSticky == 1'b0, "R8 no fault E1 medium", int'(errSticky), 0);

    // R5 fast writer absorbed by wide tracking
    doReset(1'b0, 1'b0, 1'b0);
    runJitter(8, 400, 1'b0, 1'b0);
    sawWide = 1'b0;
    runJitter(7, 4000, 1'b0, 1'b0);
    check(errSticky == 1'b0, "R5 no overflow with fast writer", int'(errSticky), 0);
    check(sawWide == 1'b1, "R5 R4 wide tracking engaged", int'(sawWide), 1);

    // R6 bwSel ignored in T1
    doReset(1'b0, 1'b0, 1'b0);
    runJitter(8, 2000, 1'b1, 1'b0);
    sigA = sig;
    doReset(1'b0, 1'b0, 1'b1);
    runJitter(8, 2000, 1'b1, 1'b0);
    check(sig == sigA, "R6 T1 read timing independent of bwSel", int'(sig[31:0]), int'(sigA[31:0]));

    // R9 underflow by starving, R4 wide while draining
    doReset(1'b0, 1'b0, 1'b0);
    runJitter(8, 600, 1'b0, 1'b1);
    trackData = 1'b0;
    sawWide = 1'b0;
    for (int c = 0; c < 600; c++) step(1'b0);
    check(sawWide == 1'b1, "R4 wide while draining", int'(sawWide), 1);
    check(errSticky == 1'b1, "R9 underflow sets flag", int'(errSticky), 1);

    // R9 overflow by flooding, hold, clear, recovery
    doReset(1'b0, 1'b0, 1'b0);
    trackData = 1'b0;
    for (int c = 0; c < 200; c++) step(1'b1);
    check(errSticky == 1'b1, "R9 overflow sets flag", int'(errSticky), 1);
    for (int c = 0; c < 20; c++) step(1'b0);
    check(errSticky == 1'b1, "R9 flag holds without clear", int'(errSticky), 1);
    @(negedge clk);
    inStrobe = 1'b0;
    errClear = 1'b1;
    step(1'b0);
    check(errSticky == 1'b0, "R9 flag cleared", int'(errSticky), 0);
    gapRem = 0;
    runJitter(8, 3000, 1'b0, 1'b1);
    check(errSticky == 1'b0, "R9 no fault after recentre", int'(errSticky), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule